// File: doc/BRIEF.md
# Dual-Path Link Message Deframer

This block sits behind the host register strobes of a link-interface device and rebuilds host-to-device messages from two ingress paths that share one framing format. On the slow path the host writes one byte at a time into an output-data register. The fast path begins when the host writes the tag byte 0x40 to that same register. After the tag, the message arrives through a FIFO port as 16-bit words. Each word is written as a low byte at the even FIFO address and then a high byte at the odd address.

Every message has the same layout. A little-endian 32-bit length word comes first. Its bits 15:0 give the payload size in bytes, and its bit 31 marks a server-class transaction. The payload follows. Its first four bytes form the little-endian action code and its next four bytes form the first data word.

When the last payload byte arrives, the block pulses a message-done strobe. In that cycle it presents the action, the first data word, the payload length and the server-class flag. The block also drives an ok-to-use-FIFO status bit. The host must see this bit set before it moves a message onto the FIFO path.

The parser has three states:
- `ST_IDLE` waits for a message.
- `ST_LEN` gathers the four length bytes.
- `ST_BODY` gathers the payload.

It moves between them through these transitions:
- **start-slow** (`ST_IDLE`→`ST_LEN`): a non-tag byte arrives on the output-data register.
- **tag** (any state→`ST_LEN`): a tag byte arrives. If this happens mid-message, it is a framing error.
- **len-done** (`ST_LEN`→`ST_BODY`): the fourth length byte arrives and the payload length is non-zero.
- **empty-done** (`ST_LEN`→`ST_IDLE`): the fourth length byte arrives and the payload length is zero.
- **body-done** (`ST_BODY`→`ST_IDLE`): the last payload byte arrives.

Top module: `lnk_deframer`

## Requirements
- R1: After reset, `fifo_ok`=1, `msg_done`=0 and `frame_err`=0. Reset also abandons any partial message and clears `frame_err`.
- R2: On the slow path, bytes written in `ST_IDLE` or slow mode to select 1 (output data) are taken in order: four length bytes (least significant first), then the payload. `msg_done` is high in the cycle after the clock edge that captures the final byte.
- R3: `msg_len` reports length-word bits 15:0 and `msg_server` reports bit 31. A length of 0 completes the message on the fourth length byte, with action and data word both 0.
- R4: `msg_action` holds payload bytes 0..3 and `msg_data0` holds payload bytes 4..7, both little-endian. Any byte beyond the payload length reads as 0.
- R5: Writing 0x40 to select 1 in `ST_IDLE` enters fast mode. The message then arrives as FIFO word writes: the low byte at select 4, then the high byte at select 5. It uses the same framing as the slow path.
- R6: When a fast-path byte count is odd, the final byte is the low half of the last word and that word's high half is dropped. FIFO writes made outside a fast-path message have no effect.
- R7: `fifo_ok` is 1 only in `ST_IDLE` and 0 while a message is in progress.
- R8: A 0x40 write to select 1 during a fast-path message restarts the parser at the length word, still in fast mode, and sets `frame_err`, which stays set until reset. During a slow-path message, 0x40 is ordinary payload data.
- R9: `msg_done` is high for exactly one cycle. The output fields keep their values until the next message begins.
- R10: Writes to selects 0, 2, 3, 6 and 7 have no effect. So does a non-0x40 write to select 1 during a fast-path message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Register select (1 output data, 4 FIFO low, 5 FIFO high) |
| reg_wdata | input | 8 | Written byte |
| fifo_ok | output | 1 | Ok-to-use-FIFO status bit |
| msg_done | output | 1 | One-cycle message-complete strobe |
| msg_action | output | 32 | Action code of the completed message |
| msg_data0 | output | 32 | First data word of the completed message |
| msg_len | output | 16 | Payload length in bytes |
| msg_server | output | 1 | Server-class flag (length bit 31) |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The main function is tried with four input patterns:
- Slow-path messages of eight, two and zero payload bytes. These tell full field capture apart from zero-filling of short payloads and from the empty-message shortcut.
- A slow-path payload that contains 0x40 bytes. This tells payload data apart from a tag.
- Fast-path messages with even and odd byte counts. These show word splitting and dropping of the surplus high half.
- Foreign-select writes, stray FIFO writes and a mid-message tag. These separate ignored traffic from a framing restart.

A scoreboard queue holds each predicted message and is compared at every `msg_done` strobe. Any strobe with no prediction waiting is reported as a mismatch.

// File: rtl/lnk_deframe_pkg.sv
package lnk_deframe_pkg;
    localparam int LEN_W  = 16;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEN,
        ST_BODY
    } dfr_state_e;
endpackage

// File: rtl/lnk_path_steer.sv
module lnk_path_steer #(
    parameter int              SEL_W       = 3,
    parameter logic [SEL_W-1:0] OUT_SEL     = 3'd1,
    parameter logic [SEL_W-1:0] FIFO_LO_SEL = 3'd4,
    parameter logic [SEL_W-1:0] FIFO_HI_SEL = 3'd5,
    parameter logic [7:0]       TAG         = 8'h40
) (
    input  logic             wr_stb,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_byte,
    input  logic             fast_mode,
    input  logic             idle,
    output logic             byte_vld,
    output logic [7:0]       byte_out,
    output logic             tag_hit
);
    logic slow_wr;
    logic fifo_wr;

    assign slow_wr = wr_stb && (wr_sel == OUT_SEL);
    assign fifo_wr = wr_stb && ((wr_sel == FIFO_LO_SEL) || (wr_sel == FIFO_HI_SEL));

    // A tag is recognised between messages or inside a fast-path message.
    assign tag_hit  = slow_wr && (wr_byte == TAG) && (idle || fast_mode);
    assign byte_vld = (slow_wr && !fast_mode && !tag_hit)
                    || (fifo_wr && fast_mode && !idle);
    assign byte_out = wr_byte;
endmodule

// File: rtl/lnk_frame_fsm.sv
module lnk_frame_fsm
    import lnk_deframe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              tag_hit,
    output logic              fast_mode,
    output logic              idle,
    output logic              done_q,
    output logic [WORD_W-1:0] action,
    output logic [WORD_W-1:0] data0,
    output logic [LEN_W-1:0]  len,
    output logic              server,
    output logic              err
);
    localparam logic [LEN_W-1:0] ACT_END = LEN_W'(4);
    localparam logic [LEN_W-1:0] D0_END  = LEN_W'(8);

    dfr_state_e        state_q, state_d;
    logic [LEN_W-1:0]  cnt_q;
    logic [WORD_W-1:0] act_q, d0_q;
    logic [LEN_W-1:0]  len_q;
    logic              srv_q, fast_q, err_q, done_now;
    logic              last_len, body_last;

    assign last_len  = (cnt_q[1:0] == 2'd3);
    assign body_last = ((cnt_q + LEN_W'(1)) == len_q);

    always_comb begin
        state_d  = state_q;
        done_now = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tag_hit || byte_vld) state_d = ST_LEN;
            end
            ST_LEN: begin
                if (tag_hit) begin
                    state_d = ST_LEN;
                end else if (byte_vld && last_len) begin
                    if (len_q == '0) begin
                        state_d  = ST_IDLE;
                        done_now = 1'b1;
                    end else begin
                        state_d = ST_BODY;
                    end
                end
            end
            ST_BODY: begin
                if (tag_hit) begin
                    state_d = ST_LEN;
                end else if (byte_vld && body_last) begin
                    state_d  = ST_IDLE;
                    done_now = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            act_q  <= '0;
            d0_q   <= '0;
            len_q  <= '0;
            srv_q  <= 1'b0;
            fast_q <= 1'b0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= done_now;
            if (tag_hit) begin
                fast_q <= 1'b1;
                cnt_q  <= '0;
                act_q  <= '0;
                d0_q   <= '0;
                len_q  <= '0;
                srv_q  <= 1'b0;
                if (state_q != ST_IDLE) err_q <= 1'b1;
            end else if (byte_vld) begin
                unique case (state_q)
                    ST_IDLE: begin
                        len_q <= {{(LEN_W-8){1'b0}}, byte_in};
                        cnt_q <= LEN_W'(1);
                        act_q <= '0;
                        d0_q  <= '0;
                        srv_q <= 1'b0;
                    end
                    ST_LEN: begin
                        if (cnt_q[1:0] == 2'd0) len_q[7:0]  <= byte_in;
                        if (cnt_q[1:0] == 2'd1) len_q[15:8] <= byte_in;
                        if (last_len) begin
                            srv_q <= byte_in[7];
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + LEN_W'(1);
                        end
                    end
                    ST_BODY: begin
                        if (cnt_q < ACT_END)
                            act_q[{cnt_q[1:0], 3'b000} +: 8] <= byte_in;
                        else if (cnt_q < D0_END)
                            d0_q[{cnt_q[1:0], 3'b000} +: 8] <= byte_in;
                        cnt_q <= cnt_q + LEN_W'(1);
                    end
                    default: cnt_q <= '0;
                endcase
            end
            if (done_now) fast_q <= 1'b0;
        end
    end

    assign fast_mode = fast_q;
    assign idle      = (state_q == ST_IDLE);
    assign action    = act_q;
    assign data0     = d0_q;
    assign len       = len_q;
    assign server    = srv_q;
    assign err       = err_q;
endmodule

// File: rtl/lnk_deframer.sv
module lnk_deframer
    import lnk_deframe_pkg::*;
#(
    parameter int              SEL_W       = 3,
    parameter logic [SEL_W-1:0] OUT_SEL     = 3'd1,
    parameter logic [SEL_W-1:0] FIFO_LO_SEL = 3'd4,
    parameter logic [SEL_W-1:0] FIFO_HI_SEL = 3'd5,
    parameter logic [7:0]       TAG         = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic              fifo_ok,
    output logic              msg_done,
    output logic [WORD_W-1:0] msg_action,
    output logic [WORD_W-1:0] msg_data0,
    output logic [LEN_W-1:0]  msg_len,
    output logic              msg_server,
    output logic              frame_err
);
    logic       fast_mode, idle, byte_vld, tag_hit;
    logic [7:0] byte_val;

    lnk_path_steer #(
        .SEL_W(SEL_W), .OUT_SEL(OUT_SEL), .FIFO_LO_SEL(FIFO_LO_SEL),
        .FIFO_HI_SEL(FIFO_HI_SEL), .TAG(TAG)
    ) u_steer (
        .wr_stb   (reg_wr),
        .wr_sel   (reg_sel),
        .wr_byte  (reg_wdata),
        .fast_mode(fast_mode),
        .idle     (idle),
        .byte_vld (byte_vld),
        .byte_out (byte_val),
        .tag_hit  (tag_hit)
    );

    lnk_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_in  (byte_val),
        .tag_hit  (tag_hit),
        .fast_mode(fast_mode),
        .idle     (idle),
        .done_q   (msg_done),
        .action   (msg_action),
        .data0    (msg_data0),
        .len      (msg_len),
        .server   (msg_server),
        .err      (frame_err)
    );

    assign fifo_ok = idle;
endmodule

// File: rtl/lnk_deframer_chk.sv
module lnk_deframer_chk #(
    parameter int              SEL_W   = 3,
    parameter logic [SEL_W-1:0] OUT_SEL = 3'd1,
    parameter logic [7:0]       TAG     = 8'h40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [SEL_W-1:0] reg_sel,
    input logic [7:0]       reg_wdata,
    input logic             fifo_ok,
    input logic             fast_mode,
    input logic             msg_done,
    input logic [31:0]      msg_action,
    input logic             frame_err
);
    logic out_wr;
    assign out_wr = reg_wr && (reg_sel == OUT_SEL);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |=> !msg_done); // R9
    AST_DONE_HOLDS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_done && !reg_wr) |=> $stable(msg_action)); // R9
    AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |-> fifo_ok); // R7
    AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ok && out_wr) |=> !fifo_ok); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err); // R8
    AST_FAST_TAG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && reg_wdata == TAG && fast_mode) |=> frame_err); // R8
    AST_SLOW_TAG_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && reg_wdata == TAG && !fast_mode && !frame_err) |=> !frame_err); // R8
endmodule

bind lnk_deframer lnk_deframer_chk #(
    .SEL_W(SEL_W), .OUT_SEL(OUT_SEL), .TAG(TAG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .fifo_ok   (fifo_ok),
    .fast_mode (fast_mode),
    .msg_done  (msg_done),
    .msg_action(msg_action),
    .frame_err (frame_err)
);

// File: tb/lnk_deframer_tb.sv
`timescale 1ns/1ps
module lnk_deframer_tb;
    localparam logic [2:0] S_OUT = 3'd1;
    localparam logic [2:0] S_LO  = 3'd4;
    localparam logic [2:0] S_HI  = 3'd5;

    typedef struct {
        logic [31:0] action;
        logic [31:0] data0;
        logic [15:0] len;
        logic        server;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        fifo_ok, msg_done, msg_server, frame_err;
    logic [31:0] msg_action, msg_data0;
    logic [15:0] msg_len;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;
    exp_t sb[$];
    logic [7:0] pbuf[$];

    always #2 clk = ~clk;

    lnk_deframer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .fifo_ok(fifo_ok), .msg_done(msg_done),
        .msg_action(msg_action), .msg_data0(msg_data0), .msg_len(msg_len),
        .msg_server(msg_server), .frame_err(frame_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] b);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = b;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Predict the message from length word and pbuf, then drive it.
    task automatic send(input bit fast, input logic [31:0] lenw, input string req);
        logic [7:0] all[$];
        exp_t e;
        e.action = '0; e.data0 = '0;
        for (int i = 0; i < pbuf.size() && i < 4; i++) e.action[8*i +: 8] = pbuf[i];
        for (int i = 4; i < pbuf.size() && i < 8; i++) e.data0[8*(i-4) +: 8] = pbuf[i];
        e.len = lenw[15:0]; e.server = lenw[31]; e.req = req;
        sb.push_back(e);
        all = {lenw[7:0], lenw[15:8], lenw[23:16], lenw[31:24]};
        foreach (pbuf[i]) all.push_back(pbuf[i]);
        if (!fast) begin
            foreach (all[i]) wr(S_OUT, all[i]);
        end else begin
            wr(S_OUT, 8'h40);
            for (int i = 0; i < all.size(); i += 2) begin
                wr(S_LO, all[i]);
                wr(S_HI, (i + 1 < all.size()) ? all[i+1] : 8'hEE);
            end
        end
        idle_cycles(2);
    endtask

    task automatic fill(input int n, input logic [7:0] base);
        pbuf.delete();
        for (int i = 0; i < n; i++) pbuf.push_back(base + 8'(i * 7));
    endtask

    // Monitor: compare each done strobe against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && msg_done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected done", msg_action, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(msg_action == e.action, {e.req, " action"}, msg_action, e.action);
                chk(msg_data0 == e.data0, {e.req, " data0"}, msg_data0, e.data0);
                chk(msg_len == e.len, {e.req, " len"}, {16'h0, msg_len}, {16'h0, e.len});
                chk(msg_server == e.server, {e.req, " server"}, {31'h0, msg_server}, {31'h0, e.server});
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(1);
        // R1 reset state
        chk(fifo_ok == 1'b1, "R1 fifo_ok", {31'h0, fifo_ok}, 32'h1);
        chk(msg_done == 1'b0, "R1 msg_done", {31'h0, msg_done}, 32'h0);
        chk(frame_err == 1'b0, "R1 frame_err", {31'h0, frame_err}, 32'h0);

        // R2 R4 slow path, full fields
        pbuf = {8'h2D, 8'h00, 8'h00, 8'h00, 8'h78, 8'h56, 8'h34, 8'h12};
        send(0, 32'h0000_0008, "R2 R4 slow8");

        // R3 zero length, server class
        pbuf.delete();
        send(0, 32'h8000_0000, "R3 empty server");

        // R4 short payload zero-fills
        pbuf = {8'hAB, 8'hCD};
        send(0, 32'h0000_0002, "R4 short2");

        // R8 slow payload carrying 0x40 bytes
        pbuf = {8'h40, 8'h40, 8'h01, 8'h02, 8'h40, 8'h03};
        send(0, 32'h0000_0006, "R8 slow 0x40 data");
        chk(frame_err == 1'b0, "R8 no err on slow 0x40", {31'h0, frame_err}, 32'h0);

        // R5 fast path, even count
        fill(12, 8'h11);
        send(1, 32'h8000_000C, "R5 fast12");
        chk(frame_err == 1'b0, "R5 no err", {31'h0, frame_err}, 32'h0);

        // R6 fast path, odd count, then stray FIFO writes
        fill(5, 8'h90);
        send(1, 32'h0000_0005, "R6 fast odd5");
        wr(S_LO, 8'h01); wr(S_HI, 8'h02); wr(S_LO, 8'h03); wr(S_HI, 8'h04);
        idle_cycles(2);
        chk(fifo_ok == 1'b1, "R6 stray fifo ignored", {31'h0, fifo_ok}, 32'h1);

        // R7 fifo_ok low mid-message, high after
        wr(S_OUT, 8'h03);
        chk(fifo_ok == 1'b0, "R7 busy", {31'h0, fifo_ok}, 32'h0);
        wr(S_OUT, 8'h00); wr(S_OUT, 8'h00); wr(S_OUT, 8'h00);
        wr(S_OUT, 8'h21);
        chk(fifo_ok == 1'b0, "R7 busy body", {31'h0, fifo_ok}, 32'h0);
        sb.push_back('{action: 32'h0000_3121, data0: 32'h0, len: 16'd3, server: 1'b0, req: "R7 slow3"});
        wr(S_OUT, 8'h31); wr(S_OUT, 8'h00);
        idle_cycles(1);
        chk(fifo_ok == 1'b1, "R7 idle after", {31'h0, fifo_ok}, 32'h1);

        // R10 foreign selects ignored mid slow message
        sb.push_back('{action: 32'h4433_2211, data0: 32'h0, len: 16'd4, server: 1'b0, req: "R10 foreign sel"});
        wr(S_OUT, 8'h04); wr(3'd0, 8'hFF); wr(3'd2, 8'hFF); wr(S_OUT, 8'h00);
        wr(3'd3, 8'hFF); wr(S_OUT, 8'h00); wr(3'd6, 8'hFF); wr(S_OUT, 8'h00);
        wr(S_OUT, 8'h11); wr(3'd7, 8'hFF); wr(S_OUT, 8'h22);
        wr(S_LO, 8'hFF); wr(S_HI, 8'hFF);
        wr(S_OUT, 8'h33); wr(S_OUT, 8'h44);
        idle_cycles(2);
        // R10 non-tag out-data write inside fast message ignored
        sb.push_back('{action: 32'h0000_0009, data0: 32'h0, len: 16'd4, server: 1'b0, req: "R10 fast stray"});
        wr(S_OUT, 8'h40);
        wr(S_LO, 8'h04); wr(S_OUT, 8'h77); wr(S_HI, 8'h00);
        wr(S_LO, 8'h00); wr(S_HI, 8'h00);
        wr(S_LO, 8'h09); wr(S_OUT, 8'h55); wr(S_HI, 8'h00);
        wr(S_LO, 8'h00); wr(S_HI, 8'h00);
        idle_cycles(2);
        chk(frame_err == 1'b0, "R10 no err", {31'h0, frame_err}, 32'h0);

        // R9 strobe is single and fields hold
        idle_cycles(3);
        chk(msg_done == 1'b0, "R9 done dropped", {31'h0, msg_done}, 32'h0);
        chk(msg_action == 32'h0000_0009, "R9 action held", msg_action, 32'h0000_0009);

        // R8 tag mid fast message restarts and flags error
        wr(S_OUT, 8'h40);
        wr(S_LO, 8'h08); wr(S_HI, 8'h00); wr(S_LO, 8'h00); wr(S_HI, 8'h00);
        wr(S_LO, 8'hDE); wr(S_HI, 8'hAD);
        fill(8, 8'h30);
        send(1, 32'h0000_0008, "R8 restart");
        chk(frame_err == 1'b1, "R8 err set", {31'h0, frame_err}, 32'h1);
        idle_cycles(4);
        chk(frame_err == 1'b1, "R8 err sticky", {31'h0, frame_err}, 32'h1);

        // R1 reset mid message
        wr(S_OUT, 8'h07); wr(S_OUT, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        idle_cycles(1);
        chk(fifo_ok == 1'b1, "R1 reset abandons", {31'h0, fifo_ok}, 32'h1);
        chk(frame_err == 1'b0, "R1 reset clears err", {31'h0, frame_err}, 32'h0);
        fill(7, 8'h55);
        send(0, 32'h0000_0007, "R1 R2 after reset");

        idle_cycles(4);
        chk(sb.size() == 0, "R2 all messages seen", sb.size(), 32'h0);
        finish_run();
    end
endmodule